// File: doc/BRIEF.md
# Nibble Register Serial Master

This block is the host side of a three-line serial link to a small timekeeping device whose registers are each four bits wide. A host hands it a single request: read or write, a 4-bit register address and, for a write, a 4-bit value. The block turns that request into one or two 8-bit command bytes and shifts them out most-significant bit first. It drives a serial clock, a chip-enable and a data line whose driver is switched by an output enable, so the one data wire can be turned around for replies.

All bus timing comes from one phase length measured in system clock cycles. The phase length is derived from the system clock frequency and a minimum phase duration. For every bit the data is placed while the serial clock is high, then the clock goes low for one phase and rises again. Between bytes, and after the last byte, the clock stays high for one extra recovery phase. A read returns the low nibble of the received byte together with a one-cycle done pulse.

The controller is one state machine with four states. ST_IDLE waits for a request and takes the IDLE->SETUP transition when one is accepted. ST_SETUP holds the clock high for one phase, with the data bit placed or about to be sampled, and goes SETUP->LOW. ST_LOW holds the clock low for one phase. It takes LOW->SETUP for the next bit, or LOW->RECOVER after the eighth bit. ST_RECOVER holds the clock high for one phase and releases the data driver. It takes RECOVER->SETUP to start the second byte, or RECOVER->IDLE when the transaction is finished.

Top module: `nib3w_master`

## Requirements
- R1: After reset, ser_clk is 1, ser_ce is 0, ser_oe is 0, busy is 0 and rd_done is 0.
- R2: A write request sends two bytes, each most-significant bit first. The first byte is 0010 in bits 7:4 with the address in bits 3:0. The second byte is 0001 in bits 7:4 with the write data in bits 3:0.
- R3: A read request sends one byte with 0110 in bits 7:4 and the address in bits 3:0. It then clocks in eight bits, first bit into bit 7. Bits 3:0 of the received byte appear on rd_data while rd_done is high for exactly one cycle, and bits 7:4 are discarded.
- R4: Every clock-low phase and every data-setup phase lasts HALF_CYC system cycles. HALF_CYC is the larger of 3 and ceil(PHASE_NS * SYS_CLK_MHZ / 1000).
- R5: For a byte the master sends, ser_oe rises one cycle after the first bit is placed on ser_do, while ser_clk is high. It stays high through the eighth rising edge and falls one cycle after it. During a received byte, ser_oe stays low.
- R6: busy rises in the cycle after a request is accepted and falls when the transaction ends. A request presented while busy is 1 is ignored.
- R7: ser_ce is high for the whole transaction and low otherwise. Whenever ser_ce is low, ser_clk is high. After each byte the clock stays high for one recovery phase of HALF_CYC cycles.
- R8: On a received byte, ser_di is sampled in the last cycle of each clock-high phase, just before ser_clk falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while busy is 0 |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 4 | Write value |
| busy | output | 1 | Transaction in progress |
| rd_done | output | 1 | One-cycle pulse marking valid read data |
| rd_data | output | 4 | Low nibble of the received byte |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_ce | output | 1 | Device chip-enable, high during a transaction |
| ser_do | output | 1 | Serial data driven by the master |
| ser_oe | output | 1 | Enable for the master's data driver |
| ser_di | input | 1 | Serial data returned by the device |

## Verification
The bench builds the block with SYS_CLK_MHZ = 10 and PHASE_NS = 700, which gives HALF_CYC = 7 with a 100 ns system clock. At that setting each transaction takes only a few hundred cycles, so every one of the sixteen addresses can be written and read back. Each measured clock-low width must come out at exactly 700 ns. A behavioural device model returns a non-zero upper nibble on every reply and changes its data line only on falling clock edges. A wrong nibble mask or a wrong sampling point therefore shows up directly in the returned values.

// File: rtl/nib3w_pkg.sv
`timescale 1ns/1ps
package nib3w_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int BIT_W  = $clog2(BYTE_W);

    // Tag bits decoded by the device; their positions are part of the protocol.
    localparam logic [BYTE_W-1:0] FLAG_READ = 8'h40;
    localparam logic [BYTE_W-1:0] TAG_ADDR  = 8'h20;
    localparam logic [BYTE_W-1:0] TAG_DATA  = 8'h10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_RECOVER
    } nib_state_e;

    // Byte opening every transaction: the address with its tag, plus the read flag for reads.
    function automatic logic [BYTE_W-1:0] first_cmd(input logic is_wr,
                                                    input logic [NIB_W-1:0] adr);
        logic [BYTE_W-1:0] tags;
        tags = is_wr ? TAG_ADDR : (TAG_ADDR | FLAG_READ);
        return tags | {{(BYTE_W-NIB_W){1'b0}}, adr};
    endfunction

    // Second byte: the data with its tag for writes, an empty capture register for reads.
    function automatic logic [BYTE_W-1:0] second_cmd(input logic is_wr,
                                                     input logic [NIB_W-1:0] val);
        return is_wr ? (TAG_DATA | {{(BYTE_W-NIB_W){1'b0}}, val}) : '0;
    endfunction

endpackage

// File: rtl/nib3w_phase_timer.sv
`timescale 1ns/1ps
module nib3w_phase_timer #(
    parameter int HALF_CYC = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic at_first,
    output logic at_second,
    output logic at_last
);
    localparam int CW = $clog2(HALF_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || at_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_first  = en && (cnt_q == '0);
    assign at_second = en && (cnt_q == CW'(1));
    assign at_last   = en && (cnt_q == CW'(HALF_CYC - 1));

    // R4: the phase counter never passes the end of a phase
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(HALF_CYC));

endmodule

// File: rtl/nib3w_shreg.sv
`timescale 1ns/1ps
module nib3w_shreg #(
    parameter int W    = 8,
    parameter int LOW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     load_val,
    input  logic             shift_out,
    input  logic             shift_in,
    input  logic             din,
    output logic             q_msb,
    output logic [LOW_W-1:0] q_low
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_val;
        end else if (shift_in) begin
            sh_q <= {sh_q[W-2:0], din};
        end else if (shift_out) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign q_msb = sh_q[W-1];
    assign q_low = sh_q[LOW_W-1:0];

    // R2: the controller never requests two shift-register operations at once
    p_one_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load, shift_in, shift_out}));

endmodule

// File: rtl/nib3w_master.sv
`timescale 1ns/1ps
module nib3w_master #(
    parameter int SYS_CLK_MHZ = 100,
    parameter int PHASE_NS    = 700
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [3:0] req_addr,
    input  logic [3:0] req_wdata,
    output logic       busy,
    output logic       rd_done,
    output logic [3:0] rd_data,
    output logic       ser_clk,
    output logic       ser_ce,
    output logic       ser_do,
    output logic       ser_oe,
    input  logic       ser_di
);
    import nib3w_pkg::*;

    localparam int RAW_HALF = (PHASE_NS * SYS_CLK_MHZ + 999) / 1000;
    localparam int HALF_CYC = (RAW_HALF < 3) ? 3 : RAW_HALF;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    nib_state_e       state_q, state_d;
    logic             ph_first, ph_second, ph_end;
    logic             wr_q;
    logic             byte_q;
    logic [BIT_W-1:0] bit_q;
    logic             rx_byte;
    logic             sh_load, sh_out, sh_in, sh_msb;
    logic [BYTE_W-1:0] sh_val;
    logic [NIB_W-1:0] sh_low;
    logic             accept;

    assign rx_byte = !wr_q && byte_q;
    assign accept  = (state_q == ST_IDLE) && req_valid;

    nib3w_phase_timer #(.HALF_CYC(HALF_CYC)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (state_q != ST_IDLE),
        .at_first  (ph_first),
        .at_second (ph_second),
        .at_last   (ph_end)
    );

    assign sh_load = accept || ((state_q == ST_RECOVER) && ph_end && !byte_q);
    assign sh_val  = (state_q == ST_IDLE) ? first_cmd(req_write, req_addr)
                                          : second_cmd(wr_q, req_wdata_q);
    assign sh_out  = (state_q == ST_LOW) && ph_end && !rx_byte;
    assign sh_in   = (state_q == ST_SETUP) && ph_end && rx_byte;

    logic [NIB_W-1:0] req_wdata_q;

    nib3w_shreg #(.W(BYTE_W), .LOW_W(NIB_W)) shreg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_val  (sh_val),
        .shift_out (sh_out),
        .shift_in  (sh_in),
        .din       (ser_di),
        .q_msb     (sh_msb),
        .q_low     (sh_low)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_SETUP;
            ST_SETUP:   if (ph_end) state_d = ST_LOW;
            ST_LOW:     if (ph_end) state_d = (bit_q == LAST_BIT) ? ST_RECOVER : ST_SETUP;
            ST_RECOVER: if (ph_end) state_d = byte_q ? ST_IDLE : ST_SETUP;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs and per-transaction registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_clk     <= 1'b1;
            ser_ce      <= 1'b0;
            ser_do      <= 1'b0;
            ser_oe      <= 1'b0;
            busy        <= 1'b0;
            rd_done     <= 1'b0;
            rd_data     <= '0;
            wr_q        <= 1'b0;
            byte_q      <= 1'b0;
            bit_q       <= '0;
            req_wdata_q <= '0;
        end else begin
            rd_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q        <= req_write;
                        req_wdata_q <= req_wdata;
                        byte_q      <= 1'b0;
                        bit_q       <= '0;
                        ser_ce      <= 1'b1;
                        busy        <= 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (ph_first && !rx_byte) ser_do <= sh_msb;
                    if (ph_second && !rx_byte && (bit_q == '0)) ser_oe <= 1'b1;
                    if (ph_end) ser_clk <= 1'b0;
                end
                ST_LOW: begin
                    if (ph_end) begin
                        ser_clk <= 1'b1;
                        if (bit_q != LAST_BIT) bit_q <= bit_q + 1'b1;
                    end
                end
                ST_RECOVER: begin
                    if (ph_first) ser_oe <= 1'b0;
                    if (ph_end) begin
                        bit_q <= '0;
                        if (!byte_q) begin
                            byte_q <= 1'b1;
                        end else begin
                            ser_ce <= 1'b0;
                            busy   <= 1'b0;
                            if (!wr_q) begin
                                rd_done <= 1'b1;
                                rd_data <= sh_low;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Width of the latest clock-low interval, kept for the timing check
    logic [15:0] low_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_len_q <= '0;
        else if (!ser_clk) low_len_q <= low_len_q + 1'b1;
        else               low_len_q <= '0;
    end

    p_idle_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_ce |-> (ser_clk && !ser_oe));

    p_low_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> (low_len_q == 16'(HALF_CYC)));

    p_oe_after_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_oe) |-> (ser_clk && $stable(ser_do)));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    p_done_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (!busy && !ser_ce));

    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (busy && ser_ce));

endmodule

// File: tb/nib3w_master_tb_top.sv
`timescale 1ns/1ps
module nib3w_master_tb_top;

    localparam int CLK_PERIOD = 100;
    localparam int SYS_MHZ    = 10;
    localparam int PH_NS      = 700;
    localparam int HALF       = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [3:0] req_addr = '0;
    logic [3:0] req_wdata = '0;
    logic       busy, rd_done, ser_clk, ser_ce, ser_do, ser_oe;
    logic [3:0] rd_data;
    logic       ser_di = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nib3w_master #(.SYS_CLK_MHZ(SYS_MHZ), .PHASE_NS(PH_NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rd_done(rd_done),
        .rd_data(rd_data), .ser_clk(ser_clk), .ser_ce(ser_ce), .ser_do(ser_do),
        .ser_oe(ser_oe), .ser_di(ser_di)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] exp_bytes[$];
    logic [3:0] exp_rd[$];
    logic [3:0] model[16];

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Behavioural device: sixteen nibble registers, replies carry 1011 in the upper nibble
    logic [3:0] dev_regs[16];
    logic [7:0] rx_sh = '0;
    int         rx_n = 0;
    logic [3:0] cur_addr = '0;
    logic [7:0] rep_byte = '0;
    int         rep_left = 0;
    int         rep_pos = 0;
    int         oe_err = 0;

    initial begin
        for (int i = 0; i < 16; i++) dev_regs[i] = 4'h0;
        forever begin
            @(ser_clk);
            if (ser_ce === 1'b1) begin
                if (ser_clk === 1'b1) begin
                    if (rep_left > 0) begin
                        if (ser_oe !== 1'b0) oe_err++;
                        rep_left--;
                    end else begin
                        if (ser_oe !== 1'b1) oe_err++;
                        rx_sh = {rx_sh[6:0], ser_do};
                        rx_n++;
                        if (rx_n == 8) begin
                            rx_n = 0;
                            // R2 / R3: tag bits and bit order of each byte sent by the master
                            if (exp_bytes.size() == 0)
                                check(0, "R2 unexpected byte", rx_sh, 0);
                            else begin
                                logic [7:0] e;
                                e = exp_bytes.pop_front();
                                check(rx_sh == e, "R2 byte on line", rx_sh, e);
                            end
                            if (rx_sh[5]) begin
                                cur_addr = rx_sh[3:0];
                                if (rx_sh[6]) begin
                                    rep_byte = {4'hB, dev_regs[cur_addr]};
                                    rep_left = 8;
                                    rep_pos  = 7;
                                    ser_di   = rep_byte[7];
                                end
                            end else if (rx_sh[4]) begin
                                dev_regs[cur_addr] = rx_sh[3:0];
                            end
                        end
                    end
                end else begin
                    if (rep_left > 0 && rep_pos > 0) begin
                        rep_pos--;
                        ser_di = rep_byte[rep_pos];
                    end
                end
            end
        end
    end

    // Clock-low width monitor (R4)
    int width_bad = 0;
    int low_seen = 0;
    initial begin
        forever begin
            realtime t0;
            @(negedge ser_clk);
            t0 = $realtime;
            @(posedge ser_clk);
            low_seen++;
            if (($realtime - t0) != real'(HALF * CLK_PERIOD)) width_bad++;
        end
    end

    // Read-result monitor: pops the scoreboard on every done pulse (R3, R8)
    initial begin
        forever begin
            @(negedge clk);
            if (rd_done === 1'b1) begin
                if (exp_rd.size() == 0)
                    check(0, "R3 unexpected done", rd_data, 0);
                else begin
                    logic [3:0] e;
                    e = exp_rd.pop_front();
                    check(rd_data == e, "R3 R8 read nibble", rd_data, e);
                end
            end
        end
    end

    task automatic issue(input bit wr, input logic [3:0] a, input logic [3:0] d);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        if (wr) begin
            exp_bytes.push_back({4'h2, a});
            exp_bytes.push_back({4'h1, d});
            model[a] = d;
        end else begin
            exp_bytes.push_back({4'h6, a});
            exp_rd.push_back(model[a]);
        end
        @(negedge clk);
        req_valid = 1'b0;
        // R6 busy after acceptance, R7 chip-enable raised
        check(busy === 1'b1, "R6 busy after accept", busy, 1);
        check(ser_ce === 1'b1, "R7 ce during transfer", ser_ce, 1);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 4'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ser_clk === 1'b1, "R1 clk idle", ser_clk, 1);
        check(ser_ce === 1'b0, "R1 ce idle", ser_ce, 0);
        check(ser_oe === 1'b0, "R1 oe idle", ser_oe, 0);
        check(busy === 1'b0, "R1 busy idle", busy, 0);
        check(rd_done === 1'b0, "R1 done idle", rd_done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Read of an unwritten register returns zero with garbage upper nibble
        issue(0, 4'h5, 4'h0);
        for (int a = 0; a < 16; a++) issue(1, 4'(a), 4'(a ^ 9));
        issue(1, 4'hF, 4'hF);
        issue(1, 4'h0, 4'h0);
        for (int a = 0; a < 16; a++) issue(0, 4'(a), 4'h0);

        // R6: request during busy is ignored
        issue(1, 4'h3, 4'h6);
        repeat (20) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h3; req_wdata = 4'h9;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, "R6 still busy", busy, 1);
        wait_idle();
        issue(0, 4'h3, 4'h0);
        wait_idle();

        // R7 lines back at idle
        check(ser_ce === 1'b0 && ser_clk === 1'b1, "R7 idle lines", {ser_ce, ser_clk}, 2'b01);
        check(exp_bytes.size() == 0, "R2 bytes drained", exp_bytes.size(), 0);
        check(exp_rd.size() == 0, "R3 reads drained", exp_rd.size(), 0);
        check(oe_err == 0, "R5 driver enable per byte", oe_err, 0);
        check(width_bad == 0 && low_seen > 0, "R4 low width", width_bad, 0);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

endmodule